// File: doc/BRIEF.md
# ARINC Word Byte-Read Buffer

This block holds the most recent 32-bit ARINC word handed over by the receive logic and lets a host fetch it over an 8-bit bus in four consecutive reads. The host strobes an active-low read line once per byte. An internal byte pointer picks the byte on the bus, and it moves on when each read pulse ends. A data-ready flag rises when a word arrives and falls when the host finishes reading the first byte.

Words come in on a valid/ready port. The block never applies back-pressure: `in_ready` is always high, and every beat with `in_valid` high is taken at that clock edge. It replaces the stored word whether or not the old word was read. Taking a word also returns the byte pointer to the first byte, even in the middle of a read sequence. The read strobe and the data-ready flag are plain control pins.

Top module: `arw_byte_reader`

## Requirements
- R1: After reset, `data_rdy` is 0, the stored word is all zeros (so `dbus` is 0x00) and the byte pointer selects the first byte.
- R2: A beat accepted with `in_valid` high sets `data_rdy` from the next clock edge, and `dbus` then shows bits 7:0 of that word.
- R3: `in_ready` is always 1. The block never stalls the word producer.
- R4: Byte k (k = 0..3) of the word is `in_word[8k+7:8k]`. ARINC bit 8k+1 is `in_word[8k]` and appears on `dbus[0]`. Successive reads return bytes 0, 1, 2, 3 in that order.
- R5: The pointer and `data_rdy` change only at the end of a read pulse. The clock edge that first samples `rd_n` high after sampling it low is that end. If the pulse read byte 0, `data_rdy` clears there. Reads of later bytes leave it low.
- R6: After byte 3 is read, the pointer wraps, so the next read returns byte 0 of the same word.
- R7: A word accepted in the middle of a read sequence replaces the stored word and returns the pointer to byte 0. The next read returns byte 0 of the new word.
- R8: When a word is accepted on the same edge as the end of a read pulse, the load wins. The pointer goes to byte 0 and `data_rdy` is 1.
- R9: A word accepted before the previous word was read replaces it, and the unread word is lost.
- R10: A read pulse moves the pointer by exactly one byte, however many cycles `rd_n` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 32 | Received word; ARINC bit 1 in bit 0 |
| in_valid | input | 1 | Word beat valid |
| in_ready | output | 1 | Always 1 |
| rd_n | input | 1 | Active-low read strobe, synchronous to clk |
| dbus | output | 8 | Currently selected byte |
| data_rdy | output | 1 | New word waiting; cleared by the first byte read |

## Verification
The assertions assume that `rd_n` is already synchronous to `clk` and that every read pulse stays low for at least one clock edge. They also assume that `in_valid` holds no X after reset. The stimulus drives every input one time unit after a rising edge and holds each read pulse low for one to five cycles. It lines up a release of `rd_n` with an `in_valid` beat on the same edge to exercise the case where the load wins.

// File: rtl/arw_pkg.sv
package arw_pkg;
  localparam int unsigned ARW_WORD_W = 32;
  localparam int unsigned ARW_BYTE_W = 8;

  // next pointer value, wrapping after the last lane
  function automatic int unsigned arw_wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/arw_strobe_edge.sv
module arw_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic done
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b1;
    else        strobe_q <= strobe_n;
  end

  // end of a low pulse: now high, last sampled low
  assign done = strobe_n & ~strobe_q;

  // R10
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/arw_byte_ptr.sv
module arw_byte_ptr #(
  parameter int unsigned N_BYTES = 4,
  localparam int unsigned IDX_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             done,
  output logic [IDX_W-1:0] idx,
  output logic             rdy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BYTES - 1);

  logic [IDX_W-1:0] idx_nx;

  always_comb begin
    idx_nx = IDX_W'(arw_pkg::arw_wrap_inc(int'(idx), N_BYTES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      rdy <= 1'b0;
    end else if (load) begin
      idx <= '0;
      rdy <= 1'b1;
    end else if (done) begin
      idx <= idx_nx;
      if (idx == '0) rdy <= 1'b0;
    end
  end

  // R2
  load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rdy && idx == '0));
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load && idx == LAST) |=> idx == '0);
  // R4
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load && idx != LAST) |=> idx == $past(idx) + 1'b1);
  // R5
  rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load && idx == '0) |=> !rdy);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !load) |=> ($stable(idx) && $stable(rdy)));
endmodule

// File: rtl/arw_word_store.sv
module arw_word_store #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned N_BYTES = WORD_W / BYTE_W,
  localparam int unsigned IDX_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] bus
);
  logic [WORD_W-1:0] word_q;
  logic [BYTE_W-1:0] lane [N_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_in;
  end

  for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
    assign lane[g] = word_q[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N_BYTES; i++) begin
      if (idx == IDX_W'(i)) bus = lane[i];
    end
  end

  // R9
  overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> word_q == $past(word_in));
  // R5
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_q));
endmodule

// File: rtl/arw_byte_reader.sv
module arw_byte_reader #(
  parameter int unsigned WORD_W = arw_pkg::ARW_WORD_W,
  parameter int unsigned BYTE_W = arw_pkg::ARW_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              rd_n,
  output logic [BYTE_W-1:0] dbus,
  output logic              data_rdy
);
  localparam int unsigned N_BYTES = WORD_W / BYTE_W;
  localparam int unsigned IDX_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;

  logic             load;
  logic             rd_done;
  logic [IDX_W-1:0] idx;

  assign in_ready = 1'b1;
  assign load     = in_valid;

  arw_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .done(rd_done)
  );

  arw_byte_ptr #(.N_BYTES(N_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(load), .done(rd_done),
    .idx(idx), .rdy(data_rdy)
  );

  arw_word_store #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(load), .word_in(in_word),
    .idx(idx), .bus(dbus)
  );

  // R7
  new_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> dbus == $past(in_word[BYTE_W-1:0]));
  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rd_done) |=> data_rdy);
endmodule

// File: tb/arw_byte_reader_tb_top.sv
module arw_byte_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        rd_n = 1'b1;
  logic [7:0]  dbus;
  logic        data_rdy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_all = 0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  arw_byte_reader dut_i (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .rd_n(rd_n), .dbus(dbus), .data_rdy(data_rdy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] lane(input logic [31:0] w, input int k);
    return w[8*k +: 8];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare the byte on the bus at the first low sample of each pulse
  logic rd_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !rd_n && rd_prev) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "scoreboard-empty", dbus, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(dbus == e.val, e.tag, dbus, e.val);
      end
    end
    rd_prev <= rd_n;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done_all) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic load_word(input logic [31:0] w);
    @(posedge clk); #1;
    in_word = w; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic read_byte(input logic [7:0] exp, input string tag, input int low_cycles);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk); #1;
    rd_n = 1'b0;
    repeat (low_cycles) @(posedge clk);
    #1 rd_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    logic [31:0] w1, w2, w3, w4, w5;
    w1 = 32'hA1B2C3D4; w2 = 32'h0F1E2D3C; w3 = 32'h11223344;
    w4 = 32'h8899AABB; w5 = 32'h5A6B7C8D;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(data_rdy == 1'b0, "R1 data_rdy after reset", data_rdy, 0);
    chk(dbus == 8'h00, "R1 bus after reset", dbus, 0);
    chk(in_ready == 1'b1, "R3 in_ready", in_ready, 1);

    load_word(w1);
    @(negedge clk);
    chk(data_rdy == 1'b1, "R2 data_rdy after load", data_rdy, 1);
    chk(dbus == lane(w1, 0), "R2 bus after load", dbus, lane(w1, 0));
    read_byte(lane(w1, 0), "R4 byte0", 1);
    @(negedge clk);
    chk(data_rdy == 1'b0, "R5 cleared by first read", data_rdy, 0);
    read_byte(lane(w1, 1), "R4 byte1", 2);
    read_byte(lane(w1, 2), "R4 byte2", 1);
    read_byte(lane(w1, 3), "R4 byte3", 3);
    read_byte(lane(w1, 0), "R6 wrap to byte0", 1);
    @(negedge clk);
    chk(data_rdy == 1'b0, "R5 stays low", data_rdy, 0);
    read_byte(lane(w1, 1), "R10 long pulse byte1", 5);
    read_byte(lane(w1, 2), "R10 single step after long pulse", 1);

    load_word(w2);
    @(negedge clk);
    chk(data_rdy == 1'b1, "R7 data_rdy mid-sequence load", data_rdy, 1);
    read_byte(lane(w2, 0), "R7 restart at byte0", 1);
    read_byte(lane(w2, 1), "R7 byte1 of new word", 1);

    load_word(w3);
    load_word(w4);
    read_byte(lane(w4, 0), "R9 unread word replaced b0", 1);
    read_byte(lane(w4, 1), "R9 unread word replaced b1", 1);

    // R8: release of rd_n and load on the same edge
    begin
      exp_t e;
      e.val = lane(w4, 2); e.tag = "R8 byte before collision";
      sb_q.push_back(e);
      @(posedge clk); #1 rd_n = 1'b0;
      @(posedge clk); #1;
      rd_n = 1'b1; in_word = w5; in_valid = 1'b1;
      @(posedge clk); #1 in_valid = 1'b0;
      @(negedge clk);
      chk(data_rdy == 1'b1, "R8 load wins data_rdy", data_rdy, 1);
      chk(dbus == lane(w5, 0), "R8 load wins pointer", dbus, lane(w5, 0));
    end
    read_byte(lane(w5, 0), "R8 next read byte0", 1);
    @(negedge clk);
    chk(data_rdy == 1'b0, "R5 cleared after R8", data_rdy, 0);
    chk(in_ready == 1'b1, "R3 in_ready still high", in_ready, 1);

    repeat (2) @(posedge clk);
    chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    done_all = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule